// File: doc/BRIEF.md
# Masked Majority Trigger Combiner

This block turns a vector of per-channel self-trigger bits into a single board-level trigger bit, one value per clock. Each channel first passes an enable mask. A neighbour-pairing stage may then merge each even/odd channel couple with OR or AND, and it drives the merged value onto both lanes of the couple. A main stage reduces all lanes with OR, AND or a per-clock majority count against a programmable level. The resulting hit feeds a gate generator. The generator either follows the hit in linear mode or stretches it to a fixed width, with or without retriggering. A final stage can invert the output polarity.

All configuration arrives on plain input ports that are expected to be static while a run is active. The gate generator is a two-state machine. `GS_IDLE` is the linear or waiting state. On `IDLE->HOLD` a hit arrives with a non-zero width, and the machine loads the counter. `HOLD->HOLD` either counts down or reloads when retriggering is on. On `HOLD->IDLE` the counter has expired or the width has been set to zero. The output is registered, so it appears one clock after the hit.

Top module: `trig_combiner_top`

## Requirements
- R1: A channel whose mask bit is 0 contributes nothing. With the main stage in OR mode, an active masked-off channel does not raise the trigger, and an active enabled channel does.
- R2: Pair mode code 0 (none) and code 3 (reserved) leave each lane equal to its own masked channel.
- R3: Pair mode code 1 (OR) and code 2 (AND) combine masked channels 2k and 2k+1 and put the same result on both lanes. In AND mode both channels must be active.
- R4: The main mode codes are 0 OR, 1 AND, 2 majority and 3 never-fire. In AND mode, masked-off lanes count as true. An all-zero mask forces the AND result low.
- R5: In majority mode the hit is true in a cycle when the number of active lanes in that cycle is at least the level. A level of 0 acts as 1. Paired lanes are counted twice.
- R6: With gate width 0 (linear), the gated output equals the hit of the previous clock.
- R7: With width W>0 and retriggering off, a hit drives the output high for exactly W clocks, starting one clock later. Hits during the pulse are ignored.
- R8: With retriggering on, a hit during the pulse reloads the counter. The output then stays high until W clocks after the last hit.
- R9: With polarity 1 the trigger output is the complement of the gated value.
- R10: During reset the gated value is 0, so the output equals the polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_trig | input | NCH | Per-channel self-trigger bits |
| cfg_mask | input | NCH | Channel enable mask |
| cfg_pair | input | 2 | Pair mode: 0 none, 1 OR, 2 AND, 3 none |
| cfg_main | input | 2 | Main mode: 0 OR, 1 AND, 2 majority, 3 off |
| cfg_level | input | CNT_W | Majority level (0 treated as 1) |
| cfg_width | input | GATE_W | Gate width in clocks, 0 = linear |
| cfg_retrig | input | 1 | 1 = retriggerable gate |
| cfg_invert | input | 1 | 1 = inverted output |
| trig_out | output | 1 | Board-level trigger |

## Verification
The hardest cases to reach from the ports are the ones inside the gate pulse: a second hit that lands while the counter is still running. Handled wrongly, that hit would either be lost or restart the pulse. The stimulus sends one hit, stays quiet for a cycle, and then sends a second hit two clocks into a four-clock pulse. The bench then counts the high cycles exactly in both gate modes. In the non-retriggerable run the pulse must end on time. In the retriggerable run the pulse must stretch by exactly the offset of the second hit. Double counting in the pair stage is exposed by setting the majority level to 2 and driving a single channel. The trigger must fire in a paired mode and stay quiet in transparent mode.

// File: rtl/trg_pkg.sv
package trg_pkg;

    typedef enum logic [1:0] {
        PAIR_NONE = 2'd0,
        PAIR_OR   = 2'd1,
        PAIR_AND  = 2'd2,
        PAIR_RSV  = 2'd3
    } pair_mode_e;

    typedef enum logic [1:0] {
        MAIN_OR  = 2'd0,
        MAIN_AND = 2'd1,
        MAIN_MAJ = 2'd2,
        MAIN_OFF = 2'd3
    } main_mode_e;

    typedef enum logic {
        GS_IDLE = 1'b0,
        GS_HOLD = 1'b1
    } gate_st_e;

endpackage

// File: rtl/trg_pair_stage.sv
module trg_pair_stage
    import trg_pkg::*;
#(
    parameter int NCH = 64
) (
    input  logic [NCH-1:0] raw,
    input  logic [NCH-1:0] mask,
    input  pair_mode_e     mode,
    output logic [NCH-1:0] lanes,
    output logic [NCH-1:0] lane_en
);
    localparam int NPAIR = NCH / 2;

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        logic a, b, ma, mb;
        assign ma = mask[2*k];
        assign mb = mask[2*k+1];
        assign a  = raw[2*k] & ma;
        assign b  = raw[2*k+1] & mb;

        always_comb begin
            unique case (mode)
                PAIR_OR: begin
                    lanes[2*k]     = a | b;
                    lanes[2*k+1]   = a | b;
                    lane_en[2*k]   = ma | mb;
                    lane_en[2*k+1] = ma | mb;
                end
                PAIR_AND: begin
                    lanes[2*k]     = a & b;
                    lanes[2*k+1]   = a & b;
                    lane_en[2*k]   = ma | mb;
                    lane_en[2*k+1] = ma | mb;
                end
                default: begin
                    lanes[2*k]     = a;
                    lanes[2*k+1]   = b;
                    lane_en[2*k]   = ma;
                    lane_en[2*k+1] = mb;
                end
            endcase
        end
    end

endmodule

// File: rtl/trg_main_logic.sv
module trg_main_logic
    import trg_pkg::*;
#(
    parameter int NCH   = 64,
    parameter int CNT_W = $clog2(NCH + 1)
) (
    input  logic [NCH-1:0]   lanes,
    input  logic [NCH-1:0]   lane_en,
    input  main_mode_e       mode,
    input  logic [CNT_W-1:0] level,
    output logic             hit
);
    function automatic logic [CNT_W-1:0] popcnt(input logic [NCH-1:0] v);
        logic [CNT_W-1:0] s;
        s = '0;
        for (int i = 0; i < NCH; i++) begin
            s = s + CNT_W'(v[i]);
        end
        return s;
    endfunction

    logic [CNT_W-1:0] active_cnt;
    logic [CNT_W-1:0] level_eff;
    logic             any_hit, all_hit, maj_hit;

    assign active_cnt = popcnt(lanes);
    assign level_eff  = (level == '0) ? CNT_W'(1) : level;
    assign any_hit    = |lanes;
    assign all_hit    = (lane_en != '0) && (&(lanes | ~lane_en));
    assign maj_hit    = (active_cnt >= level_eff);

    always_comb begin
        unique case (mode)
            MAIN_OR:  hit = any_hit;
            MAIN_AND: hit = all_hit;
            MAIN_MAJ: hit = maj_hit;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/trg_gate_fsm.sv
module trg_gate_fsm
    import trg_pkg::*;
#(
    parameter int GATE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [GATE_W-1:0] width,
    input  logic              retrig,
    output logic              gate_q
);
    gate_st_e          st_q, st_nxt;
    logic [GATE_W-1:0] cnt_q, cnt_nxt;
    logic              out_nxt;
    logic [GATE_W-1:0] reload;

    assign reload = width - GATE_W'(1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= GS_IDLE;
            cnt_q  <= '0;
            gate_q <= 1'b0;
        end else begin
            st_q   <= st_nxt;
            cnt_q  <= cnt_nxt;
            gate_q <= out_nxt;
        end
    end

    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = cnt_q;
        out_nxt = 1'b0;
        unique case (st_q)
            GS_IDLE: begin
                if (width == '0) begin
                    out_nxt = hit;
                end else if (hit) begin
                    st_nxt  = GS_HOLD;
                    cnt_nxt = reload;
                    out_nxt = 1'b1;
                end
            end
            GS_HOLD: begin
                if (width == '0) begin
                    st_nxt  = GS_IDLE;
                    cnt_nxt = '0;
                    out_nxt = hit;
                end else if (retrig && hit) begin
                    cnt_nxt = reload;
                    out_nxt = 1'b1;
                end else if (cnt_q == '0) begin
                    st_nxt  = GS_IDLE;
                    out_nxt = 1'b0;
                end else begin
                    cnt_nxt = cnt_q - GATE_W'(1);
                    out_nxt = 1'b1;
                end
            end
            default: begin
                st_nxt = GS_IDLE;
            end
        endcase
    end

    AST_LINEAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (width == '0) |=> (gate_q == $past(hit)));                         // R6
    AST_GATE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == GS_IDLE && width != '0 && hit) |=> (gate_q && st_q == GS_HOLD)); // R7
    AST_NORETRIG_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (!retrig && st_q == GS_HOLD && cnt_q != '0 && width != '0)
        |=> (st_q == GS_HOLD && gate_q && cnt_q == $past(cnt_q) - GATE_W'(1))); // R7
    AST_RETRIG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (retrig && st_q == GS_HOLD && hit && width != '0)
        |=> (gate_q && cnt_q == $past(width) - GATE_W'(1)));              // R8

endmodule

// File: rtl/trig_combiner_top.sv
module trig_combiner_top
    import trg_pkg::*;
#(
    parameter int NCH    = 64,
    parameter int GATE_W = 16,
    localparam int CNT_W = $clog2(NCH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    chan_trig,
    input  logic [NCH-1:0]    cfg_mask,
    input  logic [1:0]        cfg_pair,
    input  logic [1:0]        cfg_main,
    input  logic [CNT_W-1:0]  cfg_level,
    input  logic [GATE_W-1:0] cfg_width,
    input  logic              cfg_retrig,
    input  logic              cfg_invert,
    output logic              trig_out
);
    logic [NCH-1:0] lanes;
    logic [NCH-1:0] lane_en;
    logic           hit;
    logic           gate_q;
    pair_mode_e     pair_mode;
    main_mode_e     main_mode;

    assign pair_mode = pair_mode_e'(cfg_pair);
    assign main_mode = main_mode_e'(cfg_main);

    trg_pair_stage #(.NCH(NCH)) u_pair (
        .raw     (chan_trig),
        .mask    (cfg_mask),
        .mode    (pair_mode),
        .lanes   (lanes),
        .lane_en (lane_en)
    );

    trg_main_logic #(.NCH(NCH), .CNT_W(CNT_W)) u_main (
        .lanes   (lanes),
        .lane_en (lane_en),
        .mode    (main_mode),
        .level   (cfg_level),
        .hit     (hit)
    );

    trg_gate_fsm #(.GATE_W(GATE_W)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .width  (cfg_width),
        .retrig (cfg_retrig),
        .gate_q (gate_q)
    );

    assign trig_out = gate_q ^ cfg_invert;

    for (genvar k = 0; k < NCH / 2; k++) begin : g_twin_chk
        AST_PAIR_TWIN: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_pair == 2'd1 || cfg_pair == 2'd2) |-> (lanes[2*k] == lanes[2*k+1])); // R3
    end

    AST_AND_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_main == 2'd1 && cfg_mask == '0) |-> !hit);                    // R4
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mask == '0 && cfg_main != 2'd1) |-> !hit);                    // R1
    AST_RESET_LOW: assert property (@(posedge clk)
        !rst_n |=> (trig_out == cfg_invert) || rst_n);                     // R10

endmodule

// File: tb/tb_trig_combiner_top.sv
module tb_trig_combiner_top;
    localparam int NCH    = 64;
    localparam int GATE_W = 16;
    localparam int CNT_W  = 7;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NCH-1:0]    chan_trig;
    logic [NCH-1:0]    cfg_mask;
    logic [1:0]        cfg_pair;
    logic [1:0]        cfg_main;
    logic [CNT_W-1:0]  cfg_level;
    logic [GATE_W-1:0] cfg_width;
    logic              cfg_retrig;
    logic              cfg_invert;
    logic              trig_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    trig_combiner_top #(.NCH(NCH), .GATE_W(GATE_W)) dut (
        .clk(clk), .rst_n(rst_n), .chan_trig(chan_trig), .cfg_mask(cfg_mask),
        .cfg_pair(cfg_pair), .cfg_main(cfg_main), .cfg_level(cfg_level),
        .cfg_width(cfg_width), .cfg_retrig(cfg_retrig), .cfg_invert(cfg_invert),
        .trig_out(trig_out)
    );

    task automatic check(input string req, input logic exp);
        n_chk++;
        if (trig_out !== exp) begin
            n_bad++;
            $display("FAIL %s: trig_out=%b expected=%b at %0t", req, trig_out, exp, $time);
        end
    endtask

    task automatic tick(input logic [NCH-1:0] c);
        chan_trig = c;
        @(negedge clk);
    endtask

    task automatic defaults();
        cfg_mask = '1; cfg_pair = 2'd0; cfg_main = 2'd0; cfg_level = 7'd1;
        cfg_width = '0; cfg_retrig = 1'b0; cfg_invert = 1'b0;
        tick('0); tick('0);
    endtask

    task automatic t_reset();
        cfg_invert = 1'b0;
        @(negedge clk);
        check("R10 reset low", 1'b0);
        cfg_invert = 1'b1;
        #1;
        check("R10 reset follows polarity", 1'b1);
        cfg_invert = 1'b0;
    endtask

    task automatic t_mask();
        defaults();
        cfg_mask = ~(64'd1 << 5);
        tick(64'd1 << 5); check("R1 masked channel ignored", 1'b0);
        tick(64'd1 << 6); check("R1 enabled channel fires", 1'b1);
        tick('0);         check("R1 idle", 1'b0);
    endtask

    task automatic t_pair_double();
        defaults();
        cfg_main = 2'd2; cfg_level = 7'd2;
        cfg_pair = 2'd1;
        tick(64'd1); check("R5 paired lane counted twice", 1'b1);
        cfg_pair = 2'd0;
        tick(64'd1); check("R2 transparent single count", 1'b0);
        cfg_pair = 2'd3;
        tick(64'd1); check("R2 reserved code transparent", 1'b0);
    endtask

    task automatic t_pair_and();
        defaults();
        cfg_pair = 2'd2;
        tick(64'h4); check("R3 pair AND one side", 1'b0);
        tick(64'hC); check("R3 pair AND both sides", 1'b1);
        cfg_pair = 2'd1;
        tick(64'h8); check("R3 pair OR one side", 1'b1);
    endtask

    task automatic t_main_and();
        defaults();
        cfg_main = 2'd1; cfg_mask = 64'hF0;
        tick(64'hF0);            check("R4 AND all enabled active", 1'b1);
        tick(64'h70);            check("R4 AND one enabled missing", 1'b0);
        tick(64'hFF00_0000_00F0); check("R4 AND ignores masked", 1'b1);
        cfg_mask = '0;
        tick('1);                check("R4 AND empty mask low", 1'b0);
        cfg_mask = '1; cfg_main = 2'd3;
        tick('1);                check("R4 reserved main mode off", 1'b0);
    endtask

    task automatic t_majority();
        defaults();
        cfg_main = 2'd2; cfg_level = 7'd3;
        tick(64'h8000_0000_0001_0001); check("R5 count equals level", 1'b1);
        tick(64'h8000_0000_0000_0001); check("R5 count below level", 1'b0);
        cfg_level = 7'd0;
        tick(64'h0010);                check("R5 level zero acts as one", 1'b1);
        tick('0);                      check("R5 level zero no inputs", 1'b0);
        cfg_level = 7'd64;
        tick('1);                      check("R5 all 64 active", 1'b1);
        tick(~64'd1);                  check("R5 63 of 64", 1'b0);
    endtask

    task automatic t_linear();
        defaults();
        tick(64'd1); check("R6 linear high", 1'b1);
        tick('0);    check("R6 linear low", 1'b0);
        tick(64'd2); check("R6 linear high again", 1'b1);
        tick('0);    check("R6 linear low again", 1'b0);
    endtask

    task automatic t_gate_fixed();
        defaults();
        cfg_width = 16'd4; cfg_retrig = 1'b0;
        tick(64'd1); check("R7 pulse cycle 1", 1'b1);
        tick('0);    check("R7 pulse cycle 2", 1'b1);
        tick(64'd1); check("R7 pulse cycle 3 hit ignored", 1'b1);
        tick('0);    check("R7 pulse cycle 4", 1'b1);
        tick('0);    check("R7 pulse ends after W", 1'b0);
        tick('0);    check("R7 stays low", 1'b0);
    endtask

    task automatic t_gate_retrig();
        defaults();
        cfg_width = 16'd4; cfg_retrig = 1'b1;
        tick(64'd1); check("R8 pulse cycle 1", 1'b1);
        tick('0);    check("R8 pulse cycle 2", 1'b1);
        tick(64'd1); check("R8 reload", 1'b1);
        tick('0);    check("R8 extended 1", 1'b1);
        tick('0);    check("R8 extended 2", 1'b1);
        tick('0);    check("R8 extended 3", 1'b1);
        tick('0);    check("R8 ends W after last hit", 1'b0);
    endtask

    task automatic t_polarity();
        defaults();
        cfg_invert = 1'b1;
        #1;
        check("R9 inverted idle", 1'b1);
        tick(64'd1); check("R9 inverted active", 1'b0);
        tick('0);    check("R9 inverted back", 1'b1);
        cfg_invert = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        chan_trig = '0; cfg_mask = '1; cfg_pair = 2'd0; cfg_main = 2'd0;
        cfg_level = 7'd1; cfg_width = '0; cfg_retrig = 1'b0; cfg_invert = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_mask();
        t_pair_double();
        t_pair_and();
        t_main_and();
        t_majority();
        t_linear();
        t_gate_fixed();
        t_gate_retrig();
        t_polarity();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule